// File: doc/BRIEF.md
# Stereo Volume and Soft-Mute Controller

This block sits in the sample path of a 16-bit stereo playback stream and applies digital attenuation in 1 dB steps. Software-side control arrives as single-cycle writes that name a target (master, left or right), a control kind (volume or mute) and a value. The block keeps a master attenuation and an attenuation for each channel. The attenuation it applies to a channel is the master value plus that channel's own value.

Every change of gain, whether from a volume write or from muting, is walked one table step per sample, so the output never jumps. Mute is only controllable at master level. A write that asks for mute on a single channel, or that names no valid target, is refused and flagged by a one-cycle stall pulse. A mono input mode copies the left input sample to both channels.

Top module: `vol_mute_ctrl`

## Requirements
- R1: After reset, out_valid and cfg_stall are low, out_left and out_right are zero, all attenuations are 0 dB and mute is off, so the first samples pass unchanged.
- R2: Each cycle with in_valid high produces exactly one result, with out_valid high in the following cycle; out_valid is low otherwise.
- R3: With applied step k (0..64), the gain is g(0)=32768 and g(k)=floor((g(k-1)*29205+16384)/32768); step 65 has gain 0. Each output is floor((s*g+16384)/32768) of the signed input s, saturated to 16 bits.
- R4: A write with cfg_kind=0 (volume) sets the attenuation in dB named by cfg_value for target 1 (left) or 2 (right) alone; values above 64 are stored as 64.
- R5: A volume write to target 0 (master) adds to both channels; the target step of a channel is min(master+channel, 64).
- R6: A write with cfg_kind=1 to target 0 mutes both channels when cfg_value bit 0 is 1 (target step 65) and unmutes when it is 0.
- R7: On each cycle with in_valid high the applied step of each channel moves by one toward its target step, after the current sample has been scaled with the old step.
- R8: A mute write to target 1 or 2, or any write to target 3, changes no setting and raises cfg_stall for the single next cycle.
- R9: Accepted writes leave cfg_stall low.
- R10: With mono_en high, in_left is the input sample for both channels and in_right is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_target | input | 2 | 0 master, 1 left, 2 right, 3 invalid |
| cfg_kind | input | 1 | 0 volume, 1 mute |
| cfg_value | input | 8 | Attenuation in dB, or mute flag in bit 0 |
| cfg_stall | output | 1 | Refused write, one cycle after it |
| mono_en | input | 1 | Use in_left for both channels |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | 16 | Signed left (or mono) sample |
| in_right | input | 16 | Signed right sample |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 16 | Signed scaled left sample |
| out_right | output | 16 | Signed scaled right sample |

## Verification
The awkward case is a mute or volume change reversed while a ramp is still in progress, since the applied step only moves when samples flow and its value is never visible directly. The bench reaches it by muting, sending only a handful of samples, unmuting and then changing the master level, so the two channels walk back toward different targets from a mid-ramp step. The clamp of the summed attenuation is reached by combining a large master value with an oversized channel value.

// File: rtl/vol_mute_ctrl.sv
module vol_mute_ctrl #(
  parameter int DW        = 16,
  parameter int MAX_ATT   = 64,
  parameter int STEP_MUL  = 29205
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_target,
  input  logic          cfg_kind,
  input  logic [7:0]    cfg_value,
  output logic          cfg_stall,
  input  logic          mono_en,
  input  logic          in_valid,
  input  logic [DW-1:0] in_left,
  input  logic [DW-1:0] in_right,
  output logic          out_valid,
  output logic [DW-1:0] out_left,
  output logic [DW-1:0] out_right
);
  localparam int MUTE_IDX = MAX_ATT + 1;
  localparam int IW       = $clog2(MUTE_IDX + 1);
  localparam int UNITY    = 1 << (DW - 1);

  function automatic logic [DW-1:0] gain_of(input int k);
    int g;
    g = UNITY;
    for (int i = 0; i < k; i++) g = (g * STEP_MUL + UNITY / 2) >>> (DW - 1);
    if (k >= MUTE_IDX) g = 0;
    return g[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] scale(input logic [DW-1:0] s, input logic [DW-1:0] g);
    logic signed [2*DW+1:0] p;
    p = (2*DW+2)'($signed(s)) * (2*DW+2)'($signed({1'b0, g}));
    p = (p + (2*DW+2)'(UNITY / 2)) >>> (DW - 1);
    if (p > (2*DW+2)'(UNITY - 1))        return DW'(UNITY - 1);
    else if (p < -(2*DW+2)'(UNITY))      return DW'(UNITY);
    else                                  return p[DW-1:0];
  endfunction

  function automatic logic [IW-1:0] step_to(input logic [IW-1:0] cur, input logic [IW-1:0] tgt);
    if (cur < tgt)      return cur + 1'b1;
    else if (cur > tgt) return cur - 1'b1;
    else                return cur;
  endfunction

  logic [DW-1:0] gtab [MUTE_IDX+1];
  for (genvar i = 0; i <= MUTE_IDX; i++) begin : g_tab
    assign gtab[i] = gain_of(i);
  end

  logic [IW-1:0] vol_m, vol_l, vol_r;
  logic          mute_r;
  logic [IW-1:0] idx_l, idx_r;
  logic [IW-1:0] tgt_l, tgt_r;
  logic [IW:0]   sum_l, sum_r;
  logic [IW-1:0] wr_vol;
  logic          refuse;
  logic [DW-1:0] src_r;

  assign wr_vol = (cfg_value > 8'(MAX_ATT)) ? IW'(MAX_ATT) : cfg_value[IW-1:0];
  assign refuse = (cfg_target == 2'd3) || (cfg_kind && cfg_target != 2'd0);
  assign sum_l  = {1'b0, vol_m} + {1'b0, vol_l};
  assign sum_r  = {1'b0, vol_m} + {1'b0, vol_r};
  assign tgt_l  = mute_r ? IW'(MUTE_IDX) : (sum_l > (IW+1)'(MAX_ATT)) ? IW'(MAX_ATT) : sum_l[IW-1:0];
  assign tgt_r  = mute_r ? IW'(MUTE_IDX) : (sum_r > (IW+1)'(MAX_ATT)) ? IW'(MAX_ATT) : sum_r[IW-1:0];
  assign src_r  = mono_en ? in_left : in_right;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vol_m <= '0; vol_l <= '0; vol_r <= '0; mute_r <= 1'b0;
      cfg_stall <= 1'b0;
    end else begin
      cfg_stall <= cfg_we && refuse;
      if (cfg_we && !refuse) begin
        if (cfg_kind) mute_r <= cfg_value[0];
        else begin
          case (cfg_target)
            2'd0:    vol_m <= wr_vol;
            2'd1:    vol_l <= wr_vol;
            default: vol_r <= wr_vol;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_l <= '0; idx_r <= '0;
      out_valid <= 1'b0; out_left <= '0; out_right <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_left  <= scale(in_left, gtab[idx_l]);
        out_right <= scale(src_r, gtab[idx_r]);
        idx_l     <= step_to(idx_l, tgt_l);
        idx_r     <= step_to(idx_r, tgt_r);
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idx_l) |-> (idx_l == $past(idx_l) + 1'b1 || idx_l + 1'b1 == $past(idx_l)));
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(idx_r));
  a_r8_stall_on_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_kind && cfg_target != 2'd0) |=> (cfg_stall && $stable(mute_r)));
  a_r9_no_stall_volume: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_kind && cfg_target != 2'd3) |=> !cfg_stall);
  a_r6_muted_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && idx_l == IW'(MUTE_IDX)) |=> out_left == '0);
  a_r10_mono_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mono_en && idx_l == idx_r) |=> out_left == out_right);
endmodule

// File: tb/tb_vol_mute_ctrl.sv
module tb_vol_mute_ctrl;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_kind = 0, mono_en = 0, in_valid = 0;
  logic [1:0] cfg_target = 0;
  logic [7:0] cfg_value = 0;
  logic [15:0] in_left = 0, in_right = 0;
  logic cfg_stall, out_valid;
  logic [15:0] out_left, out_right;

  vol_mute_ctrl dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] expq [$];
  int m_vol [3];
  bit m_mute;
  int m_il, m_ir;

  function automatic int gain(int k);
    int g = 32768;
    if (k >= 65) return 0;
    for (int i = 0; i < k; i++) g = (g * 29205 + 16384) >>> 15;
    return g;
  endfunction

  function automatic logic [15:0] mul(logic [15:0] s, int k);
    longint p = (longint'($signed(s)) * gain(k) + 16384) >>> 15;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return 16'(p);
  endfunction

  function automatic int tgt(int ch);
    int s;
    if (m_mute) return 65;
    s = m_vol[0] + m_vol[ch];
    return (s > 64) ? 64 : s;
  endfunction

  function automatic int stepm(int cur, int t);
    return (cur < t) ? cur + 1 : (cur > t) ? cur - 1 : cur;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3 R7 R10: driver pushes expected result and advances model step
  task automatic send(logic [15:0] l, logic [15:0] r);
    logic [15:0] rs = mono_en ? l : r;
    expq.push_back({mul(l, m_il), mul(rs, m_ir)});
    m_il = stepm(m_il, tgt(1));
    m_ir = stepm(m_ir, tgt(2));
    @(negedge clk);
    in_valid = 1; in_left = l; in_right = r;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic burst(int n, int seed);
    for (int i = 0; i < n; i++)
      send(16'((seed * 7919 + i * 4099) ^ (i << 11)), 16'(-(seed * 313 + i * 2741)));
  endtask

  task automatic write(int t, bit k, int v, bit exp_stall, string req);
    @(negedge clk);
    cfg_we = 1; cfg_target = 2'(t); cfg_kind = k; cfg_value = 8'(v);
    @(negedge clk);
    cfg_we = 0;
    check(cfg_stall == exp_stall, req, cfg_stall, exp_stall);
    @(negedge clk);
    check(cfg_stall == 0, "R8 stall single cycle", cfg_stall, 0);
    if (!exp_stall) begin
      if (k) m_mute = v[0];
      else m_vol[t] = (v > 64) ? 64 : v;
    end
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && out_valid) begin
      logic [31:0] e;
      if (expq.size() == 0) check(0, "R2 unexpected output", 1, 0);
      else begin
        e = expq.pop_front();
        check(out_left == e[31:16], "R3/R4/R5/R6 left", $signed(out_left), $signed(e[31:16]));
        check(out_right == e[15:0], "R3/R4/R5/R6 right", $signed(out_right), $signed(e[15:0]));
      end
    end
  end

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_vol = '{0, 0, 0}; m_mute = 0; m_il = 0; m_ir = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0 && cfg_stall == 0, "R1 reset flags", {out_valid, cfg_stall}, 0);
    check(out_left == 0 && out_right == 0, "R1 reset data", out_left, 0);
    send(16'h7fff, 16'h8000);                      // R1 unity passes
    burst(4, 1);
    write(1, 0, 6, 0, "R9 left volume accepted");  // R4
    write(2, 0, 100, 0, "R9 right volume accepted"); // R4 clamp to 64
    burst(70, 2);
    write(0, 0, 40, 0, "R9 master volume accepted"); // R5 sum clamp
    burst(45, 3);
    write(1, 1, 1, 1, "R8 left mute refused");
    write(2, 1, 1, 1, "R8 right mute refused");
    write(3, 0, 5, 1, "R8 invalid target refused");
    burst(5, 4);                                   // R8 settings unchanged
    write(0, 1, 1, 0, "R9 master mute accepted");  // R6
    burst(8, 5);
    write(0, 1, 0, 0, "R9 master unmute accepted"); // R7 mid-ramp reversal
    write(0, 0, 0, 0, "R9 master volume to 0");
    burst(30, 6);
    write(0, 1, 1, 0, "R6 mute again");
    burst(70, 7);                                  // R6 reaches zero
    write(0, 1, 0, 0, "R6 unmute");
    write(1, 0, 0, 0, "R4 left 0 dB");
    mono_en = 1;                                   // R10
    burst(70, 8);
    mono_en = 0;
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R2 all results seen", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule